// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the status flags of an I2C controller. It watches the SCL and SDA wires through a synchronizer and detects START and STOP conditions. A bit counter finds the acknowledge slot of every byte. The block also takes a few control inputs that describe the state of the master and slave sides. From these it keeps seven flags: byte done, addressed as slave, bus busy, arbitration lost, slave direction, interrupt pending and received acknowledge. Software reads the flags as one byte through a read port.

Software clears the two sticky flags, arbitration lost and interrupt pending, by writing a zero to their bit position. A write to the control register clears the addressed-as-slave flag. The interrupt request is the interrupt-pending flag gated by an enable input. The byte datapath, SCL generation and the address, data and frequency registers live elsewhere and reach this block as plain inputs.

Top module: `i2c_stat_ctl`

## Requirements
- R1: The status byte `stat_rdata` has this layout: bit 7 byte done, bit 6 addressed as slave, bit 5 bus busy, bit 4 arbitration lost, bit 3 always 0, bit 2 slave direction, bit 1 interrupt pending, bit 0 received acknowledge. After reset it reads 0x80.
- R2: Byte done (bit 7) goes to 0 at the SCL falling edge that ends the first bit of a byte. It goes to 1 at the SCL falling edge that ends the ninth bit, which is the acknowledge slot.
- R3: A START (SDA falls while SCL is high) sets bus busy (bit 5) and restarts the bit count. A STOP (SDA rises while SCL is high) clears bus busy.
- R4: Arbitration lost (bit 4) is set when the master drives SDA high (`sda_drive_hi`=1) and SDA reads low at an SCL rising edge. This applies to bits 1 to 8 of a byte in master transmit mode (`ctl_master`=1, `ctl_tx`=1) and to bit 9 in master receive mode (`ctl_tx`=0).
- R5: Arbitration lost is also set in three other cases. The first is a `start_req` pulse while the bus is busy. The second is a `rstart_req` pulse while `ctl_master`=0. The third is a STOP on the bus while `ctl_master`=1 and `stop_req`=0.
- R6: A status write (`stat_wr`) with 0 in bit 4 clears arbitration lost, and one with 0 in bit 1 clears interrupt pending. Writing 1 to these bits changes nothing. The other bits ignore status writes. If a hardware set and a software clear fall in the same cycle, the flag stays set.
- R7: At the end of the first byte after a START, with `ctl_master`=0, the received bits 8..2 may equal `own_addr`. In that case addressed-as-slave (bit 6) is set and slave direction (bit 2) takes the eighth received bit (1 means the master reads). A mismatch leaves both bits unchanged. A `ctl_wr` pulse clears bit 6.
- R8: Interrupt pending (bit 1) is set on byte completion, on an address match and on arbitration loss. `irq` equals bit 1 AND `irq_en`.
- R9: Received acknowledge (bit 0) takes the SDA level at the rising SCL edge of the ninth bit. 0 means an acknowledge was received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| ctl_master | input | 1 | Controller is in master mode |
| ctl_tx | input | 1 | Controller is in transmit mode |
| sda_drive_hi | input | 1 | Master is releasing SDA and expects it high |
| start_req | input | 1 | One-cycle pulse: software asks for a START |
| rstart_req | input | 1 | One-cycle pulse: software asks for a repeated START |
| stop_req | input | 1 | Level: the master has asked for a STOP |
| own_addr | input | 7 | Programmed own slave address |
| irq_en | input | 1 | Interrupt enable |
| ctl_wr | input | 1 | One-cycle pulse: write to the control register |
| stat_wr | input | 1 | One-cycle pulse: write to the status register |
| stat_wdata | input | 8 | Status write data |
| stat_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a START without clocking a bit, to catch a design that clears byte done on the start hold edge. It sends a STOP right after an acknowledge, to catch a design that clears byte done on the SCL rise inside the STOP. It also sends an address that differs from the own address, because a design that sets the addressed flag on any address would show bit 6 there.

Each of the five arbitration causes is raised on its own. A slip in one of them shows as a missing bit 4 or a missing interrupt. The bench also writs all ones to the status register, and it pulses a START request in the same cycle as a clearing write. A design with the wrong write polarity or the wrong priority would drop a flag in these cases.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ACK_SLOT  = BYTE_BITS + 1;
  localparam int CNT_W     = $clog2(ACK_SLOT + 1);

  localparam int B_DONE = 7;
  localparam int B_AAS  = 6;
  localparam int B_BUSY = 5;
  localparam int B_ARB  = 4;
  localparam int B_RSV  = 3;
  localparam int B_DIR  = 2;
  localparam int B_PEND = 1;
  localparam int B_ACK  = 0;

  typedef logic [CNT_W-1:0] bitcnt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = din;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  // idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  output logic          start_ev,
  output logic          stop_ev,
  output logic          scl_rise,
  output logic          ninth_fall,
  output logic          first_fall,
  output bitcnt_t       cnt_nx,
  output logic          first_byte,
  output logic [BYTE_BITS-1:0] shift_q
);
  logic    scl_p, sda_p;
  logic    scl_fall;
  bitcnt_t cnt_q, cnt_d;
  logic    first_d;
  logic [BYTE_BITS-1:0] shift_d;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  assign ninth_fall = scl_fall && (cnt_q == bitcnt_t'(ACK_SLOT));
  assign first_fall = scl_fall && (cnt_q == bitcnt_t'(1));

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_byte;
    shift_d = shift_q;
    cnt_nx  = (cnt_q == bitcnt_t'(ACK_SLOT)) ? bitcnt_t'(1) : cnt_q + bitcnt_t'(1);
    if (start_ev) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else begin
      if (scl_rise) begin
        cnt_d = cnt_nx;
        if (cnt_nx <= bitcnt_t'(BYTE_BITS)) shift_d = {shift_q[BYTE_BITS-2:0], sda_s};
      end
      if (ninth_fall) first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p      <= 1'b1;
      sda_p      <= 1'b1;
      cnt_q      <= '0;
      first_byte <= 1'b0;
      shift_q    <= '0;
    end else begin
      scl_p      <= scl_s;
      sda_p      <= sda_s;
      cnt_q      <= cnt_d;
      first_byte <= first_d;
      shift_q    <= shift_d;
    end
  end
endmodule

// File: rtl/i2c_arb_mon.sv
module i2c_arb_mon
  import i2c_stat_pkg::*;
(
  input  logic    sda_s,
  input  logic    scl_rise,
  input  logic    stop_ev,
  input  bitcnt_t cnt_nx,
  input  logic    ctl_master,
  input  logic    ctl_tx,
  input  logic    sda_drive_hi,
  input  logic    start_req,
  input  logic    rstart_req,
  input  logic    stop_req,
  input  logic    busy,
  output logic    arb_set
);
  logic data_slot, ack_slot, mismatch;

  always_comb begin
    data_slot = (cnt_nx >= bitcnt_t'(1)) && (cnt_nx <= bitcnt_t'(BYTE_BITS));
    ack_slot  = (cnt_nx == bitcnt_t'(ACK_SLOT));
    mismatch  = ctl_master && scl_rise && sda_drive_hi && !sda_s &&
                ((ctl_tx && data_slot) || (!ctl_tx && ack_slot));
    arb_set   = mismatch
              || (start_req && busy)
              || (rstart_req && !ctl_master)
              || (stop_ev && ctl_master && !stop_req);
  end
endmodule

// File: rtl/i2c_stat_ctl.sv
module i2c_stat_ctl
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              ctl_master,
  input  logic              ctl_tx,
  input  logic              sda_drive_hi,
  input  logic              start_req,
  input  logic              rstart_req,
  input  logic              stop_req,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              irq_en,
  input  logic              ctl_wr,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  output logic [7:0]        stat_rdata,
  output logic              irq
);
  logic rst_meta, rst_sync_n;
  logic scl_s, sda_s;
  logic start_ev, stop_ev, scl_rise, ninth_fall, first_fall, first_byte;
  bitcnt_t cnt_nx;
  logic [BYTE_BITS-1:0] shift_q;
  logic arb_set, addr_hit;

  logic done_q, aas_q, busy_q, arb_q, dir_q, pend_q, ack_q;
  logic done_d, aas_d, busy_d, arb_d, dir_d, pend_d, ack_d;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(scl_in), .dout(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(sda_in), .dout(sda_s));

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
    .ninth_fall(ninth_fall), .first_fall(first_fall), .cnt_nx(cnt_nx),
    .first_byte(first_byte), .shift_q(shift_q));

  i2c_arb_mon u_arb (
    .sda_s(sda_s), .scl_rise(scl_rise), .stop_ev(stop_ev), .cnt_nx(cnt_nx),
    .ctl_master(ctl_master), .ctl_tx(ctl_tx), .sda_drive_hi(sda_drive_hi),
    .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
    .busy(busy_q), .arb_set(arb_set));

  assign addr_hit = ninth_fall && first_byte && !ctl_master &&
                    (shift_q[BYTE_BITS-1:1] == own_addr);

  always_comb begin
    done_d = done_q;
    if (ninth_fall)      done_d = 1'b1;
    else if (first_fall) done_d = 1'b0;

    busy_d = busy_q;
    if (start_ev)        busy_d = 1'b1;
    else if (stop_ev)    busy_d = 1'b0;

    aas_d = aas_q;
    if (addr_hit)        aas_d = 1'b1;
    else if (ctl_wr)     aas_d = 1'b0;

    dir_d = addr_hit ? shift_q[0] : dir_q;

    ack_d = (scl_rise && cnt_nx == bitcnt_t'(ACK_SLOT)) ? sda_s : ack_q;

    arb_d = arb_q;
    if (arb_set)                          arb_d = 1'b1;
    else if (stat_wr && !stat_wdata[B_ARB]) arb_d = 1'b0;

    pend_d = pend_q;
    if (ninth_fall || addr_hit || arb_set)   pend_d = 1'b1;
    else if (stat_wr && !stat_wdata[B_PEND]) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b1;
      aas_q  <= 1'b0;
      busy_q <= 1'b0;
      arb_q  <= 1'b0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      aas_q  <= aas_d;
      busy_q <= busy_d;
      arb_q  <= arb_d;
      dir_q  <= dir_d;
      pend_q <= pend_d;
      ack_q  <= ack_d;
    end
  end

  always_comb begin
    stat_rdata         = '0;
    stat_rdata[B_DONE] = done_q;
    stat_rdata[B_AAS]  = aas_q;
    stat_rdata[B_BUSY] = busy_q;
    stat_rdata[B_ARB]  = arb_q;
    stat_rdata[B_DIR]  = dir_q;
    stat_rdata[B_PEND] = pend_q;
    stat_rdata[B_ACK]  = ack_q;
  end

  assign irq = pend_q & irq_en;
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat_rdata,
  input logic       irq,
  input logic       irq_en,
  input logic       stat_wr,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       ninth_fall
);
  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[3] == 1'b0);

  assert_done_ninth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_fall |=> stat_rdata[7]);

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> stat_rdata[5]);

  assert_idle_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> !stat_rdata[5]);

  assert_arb_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[4] && !stat_wr) |=> stat_rdata[4]);

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[1] && !stat_wr) |=> stat_rdata[1]);

  assert_arb_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[4]) |-> stat_rdata[1]);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && stat_rdata[1]));
endmodule

bind i2c_stat_ctl i2c_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rdata(stat_rdata), .irq(irq),
  .irq_en(irq_en), .stat_wr(stat_wr), .start_ev(start_ev),
  .stop_ev(stop_ev), .ninth_fall(ninth_fall));

// File: tb/sim_i2c_stat_ctl.sv
module sim_i2c_stat_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic ctl_master = 1'b0, ctl_tx = 1'b0, sda_drive_hi = 1'b0;
  logic start_req = 1'b0, rstart_req = 1'b0, stop_req = 1'b0;
  logic [6:0] own_addr = 7'h3A;
  logic irq_en = 1'b0, ctl_wr = 1'b0, stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] stat_rdata;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  i2c_stat_ctl u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .ctl_master(ctl_master), .ctl_tx(ctl_tx), .sda_drive_hi(sda_drive_hi),
    .start_req(start_req), .rstart_req(rstart_req), .stop_req(stop_req),
    .own_addr(own_addr), .irq_en(irq_en), .ctl_wr(ctl_wr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .irq(irq));

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (stat_rdata !== e.st || irq !== e.irq) begin
          failures++;
          $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                   e.req, stat_rdata, irq, e.st, e.irq);
        end
      end
    end
  end

  task automatic expect_st(input logic [7:0] st, input logic ir, input string req);
    exp_t e;
    e.st = st; e.irq = ir; e.req = req;
    sb_q.push_back(e);
    while (sb_q.size() > 0) @(posedge clk);
  endtask

  task automatic bus(input logic c, input logic d);
    @(negedge clk);
    scl_in = c; sda_in = d;
    repeat (6) @(posedge clk);
  endtask

  task automatic do_start();
    bus(1, 1); bus(1, 0); bus(0, 0);
  endtask

  task automatic do_stop();
    bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  task automatic send_bit(input logic b);
    bus(0, b); bus(1, b); bus(0, b);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk); stat_wr = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse_ctl_wr();
    @(negedge clk); ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: stat=%h irq=%b expected completion", stat_rdata, irq);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    expect_st(8'h80, 1'b0, "R1 reset value");

    // START only: busy set, done untouched by the hold edge
    do_start();
    expect_st(8'hA0, 1'b0, "R3 busy after START, R2 done kept");

    // slave address 0x3A read, acked
    send_bit(1'b0);
    expect_st(8'h20, 1'b0, "R2 done cleared after first bit");
    for (int i = 6; i >= 0; i--) send_bit(8'h75 >> i);
    send_bit(1'b0);
    expect_st(8'hE6, 1'b0, "R7 R8 R9 address match read, irq masked");
    @(negedge clk) irq_en = 1'b1;
    repeat (2) @(posedge clk);
    expect_st(8'hE6, 1'b1, "R8 irq follows enable");

    wr_stat(8'hFF);
    expect_st(8'hE6, 1'b1, "R6 writing ones has no effect");
    wr_stat(8'h00);
    expect_st(8'hE4, 1'b0, "R6 writing zero clears pending");
    pulse_ctl_wr();
    expect_st(8'hA4, 1'b0, "R7 control write clears addressed");
    do_stop();
    expect_st(8'h84, 1'b0, "R3 STOP clears busy, R2 done kept");

    // mismatched address write, not acked
    do_start();
    send_byte(8'h22, 1'b1);
    expect_st(8'hA7, 1'b1, "R7 mismatch leaves addressed clear, R9 nack");
    wr_stat(8'hFD);
    do_stop();
    expect_st(8'h85, 1'b0, "R6 pending cleared by zero in bit 1");

    // master transmit loses a data bit
    @(negedge clk) begin ctl_master = 1'b1; ctl_tx = 1'b1; stop_req = 1'b1; end
    do_start();
    @(negedge clk) sda_drive_hi = 1'b1;
    send_bit(1'b0);
    @(negedge clk) sda_drive_hi = 1'b0;
    expect_st(8'h37, 1'b1, "R4 data bit mismatch in transmit");
    wr_stat(8'h00);
    expect_st(8'h25, 1'b0, "R6 clear arbitration and pending");
    do_stop();
    expect_st(8'h05, 1'b0, "R5 requested STOP is not a loss");

    // unrequested STOP in master mode
    @(negedge clk) stop_req = 1'b0;
    do_start();
    do_stop();
    expect_st(8'h17, 1'b1, "R5 unrequested STOP");
    wr_stat(8'h00);

    // START request while busy
    do_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    repeat (2) @(posedge clk);
    expect_st(8'h37, 1'b1, "R5 START request while busy");
    wr_stat(8'h00);

    // repeated START request in slave mode
    @(negedge clk) ctl_master = 1'b0;
    @(negedge clk) rstart_req = 1'b1;
    @(negedge clk) rstart_req = 1'b0;
    repeat (2) @(posedge clk);
    expect_st(8'h37, 1'b1, "R5 repeated START request as slave");
    wr_stat(8'h00);
    expect_st(8'h25, 1'b0, "R6 cleared after slave restart loss");

    // hardware set and software clear in the same cycle
    @(negedge clk) begin start_req = 1'b1; stat_wr = 1'b1; stat_wdata = 8'h00; end
    @(negedge clk) begin start_req = 1'b0; stat_wr = 1'b0; end
    repeat (2) @(posedge clk);
    expect_st(8'h37, 1'b1, "R6 hardware set wins over clear");
    wr_stat(8'h00);
    do_stop();
    expect_st(8'h05, 1'b0, "R3 idle after slave STOP");

    // master receive: releases SDA in ack slot but line is low
    @(negedge clk) begin ctl_master = 1'b1; ctl_tx = 1'b0; stop_req = 1'b1; end
    do_start();
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    @(negedge clk) sda_drive_hi = 1'b1;
    send_bit(1'b0);
    @(negedge clk) sda_drive_hi = 1'b0;
    expect_st(8'hB6, 1'b1, "R4 ack slot mismatch in receive, R2 done");

    done = 1'b1;
    finish_run();
  end
endmodule